// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port attached to a simple byte-wide register bus. Each pin has its own direction bit and its own output latch bit. Pads driven from outside pass through a two-stage synchroniser before the bus can see them.

The data register has no single address. It is reached through a window of byte offsets, and address bits [9:2] of each access act as a pin mask. A write changes only the pins whose mask bit is set. A read returns zero for every pin whose mask bit is clear. Software can therefore set, clear or toggle any group of pins with one write and no read-modify-write sequence. Address bits [1:0] are ignored inside the window.

A direction register and a spare mode register sit above the window. Read data is combinational from the current address and state. The bus returns zero whenever it is idle.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction, output latch and mode registers are all 0, so `padOe` and `padOut` are 0.
- R2: A write whose offset is below 0x400 loads `busWdata[n]` into output latch bit n for every pin n with address bit (n+2) set. Latch bits whose address bit is clear keep their value.
- R3: A data-window write at offset 0x000 (mask all zero) leaves the output latch unchanged.
- R4: A read whose offset is below 0x400 returns 0 on every bit n whose address bit (n+2) is clear.
- R5: On a data read of an enabled pin n, the returned bit is the output latch bit when direction bit n is 1 (output). It is the synchronised pad bit when direction bit n is 0 (input).
- R6: A change on `padIn` becomes visible to data reads after exactly two rising clock edges, and not after one.
- R7: The direction register at offset 0x400 reads back as written and drives `padOe` (bit n = 1 means pin n is an output).
- R8: The mode register at offset 0x420 reads back as written and has no effect on `padOut` or `padOe`.
- R9: Reads of any other offset at or above 0x400 return 0. Writes to such offsets change no register.
- R10: `busRdata` is 0 whenever `busSel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| padIn | input | 8 | Asynchronous pad inputs |
| padOut | output | 8 | Output latch to pads |
| padOe | output | 8 | Per-pin output enable (direction) |

## Verification
The bench builds the block with its defaults: eight pins and a 12-bit offset. With these values the mask field spans bits [9:2], the direction register sits at 0x400 and the mode register at 0x420, so every mask pattern and both named registers can be reached. Single-pin, two-pin, full and empty masks are applied to writes and reads. A mixed direction setting shows latch and pad bits side by side in one read. The pad path is timed edge by edge.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic modeWr;
    logic dataRd;
    logic dirRd;
    logic modeRd;
  } gpioStrobes_t;
endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  output gpioStrobes_t        strobes,
  output logic [NUM_PINS-1:0] pinMask
);
  localparam logic [ADDR_W-1:0] DIR_OFF  = ADDR_W'(1) << (NUM_PINS + 2);
  localparam logic [ADDR_W-1:0] MODE_OFF = DIR_OFF + ADDR_W'(32);

  logic inWindow, hitDir, hitMode, doWr, doRd;

  always_comb begin
    inWindow = busAddr < DIR_OFF;
    hitDir   = busAddr == DIR_OFF;
    hitMode  = busAddr == MODE_OFF;
    doWr     = busSel && busWrite;
    doRd     = busSel && !busWrite;
    pinMask  = busAddr[NUM_PINS+1:2];

    strobes.dataWr = doWr && inWindow;
    strobes.dirWr  = doWr && hitDir;
    strobes.modeWr = doWr && hitMode;
    strobes.dataRd = doRd && inWindow;
    strobes.dirRd  = doRd && hitDir;
    strobes.modeRd = doRd && hitMode;
  end
endmodule

// File: rtl/gpio_mask_dpath.sv
module gpio_mask_dpath
  import gpio_mask_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] pinMask,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  logic [NUM_PINS-1:0] outLatch, dirReg, modeReg;
  logic [NUM_PINS-1:0] syncA, syncB;
  logic [NUM_PINS-1:0] pinView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      dirReg   <= '0;
      modeReg  <= '0;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (strobes.dataWr) outLatch <= (outLatch & ~pinMask) | (wrData & pinMask);
      if (strobes.dirWr)  dirReg   <= wrData;
      if (strobes.modeWr) modeReg  <= wrData;
    end
  end

  // Per-pin source select: latch for outputs, synchronised pad for inputs.
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    assign pinView[p] = dirReg[p] ? outLatch[p] : syncB[p];
  end

  always_comb begin
    rdData = '0;
    if (strobes.dataRd)     rdData = pinView & pinMask;
    else if (strobes.dirRd)  rdData = dirReg;
    else if (strobes.modeRd) rdData = modeReg;
  end

  assign padOut = outLatch;
  assign padOe  = dirReg;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  gpioStrobes_t        strobes;
  logic [NUM_PINS-1:0] pinMask;

  gpio_mask_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strobes(strobes), .pinMask(pinMask)
  );

  gpio_mask_dpath #(.NUM_PINS(NUM_PINS)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pinMask(pinMask),
    .wrData(busWdata), .rdData(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] busRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << (NUM_PINS + 2);

  logic                isData;
  logic [NUM_PINS-1:0] accMask;
  assign isData  = busAddr < DIR_ADDR;
  assign accMask = busAddr[NUM_PINS+1:2];

  assert_masked_bits_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && isData) |=>
      ((padOut & $past(accMask)) == ($past(busWdata) & $past(accMask))));

  assert_unmasked_bits_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && isData) |=>
      ((padOut & ~$past(accMask)) == ($past(padOut) & ~$past(accMask))));

  assert_read_mask_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && isData) |-> ((busRdata & ~accMask) == '0));

  assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == DIR_ADDR) |=> (padOe == $past(busWdata)));

  assert_no_write_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> ($stable(padOut) && $stable(padOe)));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic       busSel = 0;
  logic       busWrite = 0;
  logic [11:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    busRd(12'h400, d); check("R1 dir", d, 8'h00);
    busRd(12'h420, d); check("R1 mode", d, 8'h00);
  endtask

  task automatic testDirection();
    logic [7:0] d;
    busWr(12'h400, 8'hA5);
    busRd(12'h400, d); check("R7 dir readback", d, 8'hA5);
    check("R7 padOe", padOe, 8'hA5);
    busWr(12'h400, 8'hFF);
    check("R7 padOe all out", padOe, 8'hFF);
  endtask

  task automatic testMaskedWrite();
    busWr(12'h3FC, 8'h00);
    check("R2 full clear", padOut, 8'h00);
    busWr(12'h020, 8'hFF);
    check("R2 pin3 only", padOut, 8'h08);
    busWr(12'h00C, 8'h02);
    check("R2 pins0,1", padOut, 8'h0A);
    busWr(12'h000, 8'hFF);
    check("R3 empty mask", padOut, 8'h0A);
    busWr(12'h203, 8'hFF);
    check("R2 pin7 low bits ignored", padOut, 8'h8A);
    busWr(12'h200, 8'h00);
    check("R2 pin7 clear", padOut, 8'h0A);
  endtask

  task automatic testMaskedRead();
    logic [7:0] d;
    busRd(12'h3FC, d); check("R4 full read", d, 8'h0A);
    busRd(12'h020, d); check("R4 pin3 read", d, 8'h08);
    busRd(12'h004, d); check("R4 pin0 read", d, 8'h00);
    busRd(12'h000, d); check("R4 empty read", d, 8'h00);
  endtask

  task automatic testMixedDir();
    logic [7:0] d;
    busWr(12'h400, 8'h0F);
    @(negedge clk) padIn = 8'h35;
    repeat (3) @(negedge clk);
    busRd(12'h3FC, d); check("R5 mixed read", d, 8'h3A);
    busRd(12'h0F0, d); check("R5 nibble read", d, 8'h3A & 8'h3C);
    check("R5 latch kept", padOut, 8'h0A);
  endtask

  task automatic testSyncTiming();
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 12'h3FC;
    padIn = 8'hC5;
    @(negedge clk);
    check("R6 one edge", busRdata, 8'h3A);
    @(negedge clk);
    check("R6 two edges", busRdata, 8'hCA);
    busSel = 0;
  endtask

  task automatic testMode();
    logic [7:0] d;
    busWr(12'h420, 8'h5C);
    busRd(12'h420, d); check("R8 mode readback", d, 8'h5C);
    check("R8 padOut unaffected", padOut, 8'h0A);
    check("R8 padOe unaffected", padOe, 8'h0F);
  endtask

  task automatic testUndefined();
    logic [7:0] d;
    busWr(12'h424, 8'hFF);
    busWr(12'h408, 8'hFF);
    busWr(12'h401, 8'hFF);
    busRd(12'h424, d); check("R9 read 0x424", d, 8'h00);
    busRd(12'h40C, d); check("R9 read 0x40C", d, 8'h00);
    busRd(12'h400, d); check("R9 dir kept", d, 8'h0F);
    busRd(12'h420, d); check("R9 mode kept", d, 8'h5C);
    check("R9 latch kept", padOut, 8'h0A);
  endtask

  task automatic testIdle();
    @(negedge clk);
    busSel = 0; busAddr = 12'h400;
    #1 check("R10 idle dir addr", busRdata, 8'h00);
    busAddr = 12'h3FC;
    #1 check("R10 idle data addr", busRdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testDirection();
    testMaskedWrite();
    testMaskedRead();
    testMixedDir();
    testSyncTiming();
    testMode();
    testUndefined();
    testIdle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule